// File: doc/BRIEF.md
# Multiplexed Eight-Digit Display Scanner with Leading-Zero Blanking

This block drives a time-multiplexed numeric display from eight latched BCD digits. A scan position steps from the most significant digit down to the least significant one and then wraps. Each step takes one cycle in which `scan_tick` is high. For the digit being shown, the block puts its BCD code on a shared nibble bus and its seven-segment pattern on a shared segment bus. It also raises that digit's strobe, so external latches can take the nibble bus apart again.

Leading zeros are suppressed by a flag that is armed at the start of every scan. The flag clears at the first nonzero digit, or when the decimal-point request goes high while a digit is shown. The least significant digit is always shown. A set overflow flag shows every digit. Raising the scan-reset input returns the scanner to the most significant digit and forces the display dark. Scan reset is synchronized inside the block, so it may change at any time. A lamp-test input lights every segment, overriding both data and blanking.

Top module: `mux_disp_scan`

## Requirements
- R1: After `rst_n` is released with all digits zero, `strobe` is 8'h80 (the most significant digit), `bcd_out` is 0, `blank_out` is 1 and `seg_out` is 0.
- R2: Each cycle with `scan_tick` high (and scan reset not active) moves the scan one digit lower. Digit 0 wraps to digit 7. `bcd_out` equals `digits[4*p+3:4*p]` for the current position p, and `strobe` bit p is the only strobe set. A cycle without `scan_tick` leaves the position unchanged.
- R3: `seg_out` bit 0 is segment a and bit 6 is segment g, active high. The codes 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, and the codes 10 to 15 give 0.
- R4: Within a scan, a zero digit is blanked while every digit shown before it in that scan was zero. The first nonzero digit is shown, and so is every later digit of the scan, including zeros.
- R5: When `dp_req` is high while a digit is shown, that digit and all remaining digits of the scan are shown even when they are zero.
- R6: Outside scan reset, digit 0 is never blanked.
- R7: Outside scan reset, while `ovf_latched` is high no digit is blanked.
- R8: `scan_rst` passes through a two-stage synchronizer. Two clock edges after it rises, `blank_out` is forced high, regardless of overflow. From the third edge on, the position stays at the most significant digit and `scan_tick` is ignored.
- R9: While `blank_out` is high and `lamp_test` is low, `seg_out` is 0. The blanking flag is re-armed at the start of every scan, so the same data gives the same blanking in each scan.
- R10: While `lamp_test` is high, `seg_out` is 7'h7F.
- R11: Exactly one strobe bit is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_tick | input | 1 | Scan advance enable, one cycle per digit step |
| scan_rst | input | 1 | Asynchronous scan restart request, high active |
| dp_req | input | 1 | Decimal-point request, unblanks from the current digit on |
| ovf_latched | input | 1 | Latched overflow flag, disables blanking |
| lamp_test | input | 1 | Lights all segments |
| digits | input | 32 | Eight BCD digits, digit p at bits 4p+3..4p |
| bcd_out | output | 4 | BCD code of the digit being shown |
| seg_out | output | 7 | Segments a..g in bits 0..6, active high |
| strobe | output | 8 | One-hot digit strobe, bit p for digit p |
| blank_out | output | 1 | High when the current digit is blanked |

## Verification
A step requested by `scan_tick` appears on `strobe`, `bcd_out` and `seg_out` immediately after the rising edge that samples the tick. The leading-zero flag is updated at that same edge. `dp_req`, `ovf_latched`, `lamp_test` and `digits` act combinationally within the same cycle. `scan_rst` forces blanking two edges after it rises and pins the position at the third edge. The bench drives every input one time unit after a rising edge and samples one time unit later, or at the falling edge after a tick. It waits at least three edges after each scan-reset change before it checks anything.

// File: rtl/disp_scan_pkg.sv
// Package: shared widths, types and the BCD to seven-segment mapping.
// Assumes segment bit 0 is a and bit 6 is g, all active high.
package disp_scan_pkg;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    localparam seg_t SEG_ALL_ON  = 7'h7F;
    localparam seg_t SEG_ALL_OFF = 7'h00;

    // Map one BCD code to its active-high a..g pattern; invalid codes stay dark.
    function automatic seg_t bcd_to_seg(input bcd_t code);
        seg_t s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = SEG_ALL_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scan_rst_sync.sv
// Module: scan_rst_sync
// Brings the asynchronous scan-restart request into the clock domain
// through a chain of STAGES flops. Assumes STAGES >= 2.
module scan_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw request through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/scan_sequencer.sv
// Module: scan_sequencer
// Holds the scan position, counting down from the most significant digit
// to digit 0 and wrapping. A hold input pins it to the most significant
// digit. Decodes the one-hot strobes. Assumes NUM_DIGITS >= 2.
module scan_sequencer #(
    parameter int NUM_DIGITS = 8,
    localparam int POS_W = $clog2(NUM_DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hold,
    input  logic                  advance,
    output logic [POS_W-1:0]      pos,
    output logic                  at_lsd,
    output logic [NUM_DIGITS-1:0] strobe
);

    localparam logic [POS_W-1:0] POS_MSD = POS_W'(NUM_DIGITS - 1);
    localparam logic [POS_W-1:0] POS_LSD = '0;

    logic [POS_W-1:0] pos_q;

    // Step the position down on each advance, wrap at digit 0, pin on hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_MSD;
        end else if (hold) begin
            pos_q <= POS_MSD;
        end else if (advance) begin
            pos_q <= (pos_q == POS_LSD) ? POS_MSD : pos_q - POS_W'(1);
        end
    end

    assign pos    = pos_q;
    assign at_lsd = (pos_q == POS_LSD);

    // One strobe comparator per digit.
    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_strobe
        assign strobe[gi] = (pos_q == POS_W'(gi));
    end

endmodule

// File: rtl/lead_blank_ctrl.sv
// Module: lead_blank_ctrl
// Leading-zero blanking flag. Armed on scan reset and at every scan start.
// Cleared by a nonzero digit being left, or by a decimal-point request.
// Assumes `advance` is already qualified with hold inactive.
module lead_blank_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic advance,
    input  logic at_lsd,
    input  logic cur_zero,
    input  logic dp_req,
    input  logic ovf,
    output logic blank
);

    logic leading_q;

    // Re-arm at scan start or on hold; clear once a digit is to be shown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leading_q <= 1'b1;
        end else if (hold || (advance && at_lsd)) begin
            leading_q <= 1'b1;
        end else if (dp_req || (advance && !cur_zero)) begin
            leading_q <= 1'b0;
        end
    end

    // Blank for a held scan, or for a still-leading zero that is neither
    // digit 0 nor excused by a decimal point or by overflow.
    always_comb begin
        blank = hold || (leading_q && cur_zero && !dp_req && !at_lsd && !ovf);
    end

endmodule

// File: rtl/seg_encoder.sv
// Module: seg_encoder
// Turns the current BCD code into a segment pattern. Blanking darkens it,
// and lamp test lights every segment over both blanking and data.
module seg_encoder
    import disp_scan_pkg::*;
(
    input  bcd_t code,
    input  logic blank,
    input  logic lamp_test,
    output seg_t seg
);

    // Pick lamp test, blank, or the decoded pattern, in that priority.
    always_comb begin
        if (lamp_test) begin
            seg = SEG_ALL_ON;
        end else if (blank) begin
            seg = SEG_ALL_OFF;
        end else begin
            seg = bcd_to_seg(code);
        end
    end

endmodule

// File: rtl/mux_disp_scan.sv
// Module: mux_disp_scan (top)
// Multiplexes NUM_DIGITS latched BCD digits onto one BCD bus and one
// segment bus, from the most significant digit down, with leading-zero
// blanking. Assumes `digits` is stable while it is scanned and that
// `scan_tick` is a single-cycle enable per step.
module mux_disp_scan
    import disp_scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int POS_W  = $clog2(NUM_DIGITS),
    localparam int DATA_W = NUM_DIGITS * BCD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_tick,
    input  logic                  scan_rst,
    input  logic                  dp_req,
    input  logic                  ovf_latched,
    input  logic                  lamp_test,
    input  logic [DATA_W-1:0]     digits,
    output logic [BCD_W-1:0]      bcd_out,
    output logic [SEG_W-1:0]      seg_out,
    output logic [NUM_DIGITS-1:0] strobe,
    output logic                  blank_out
);

    logic             scan_hold;
    logic             step;
    logic [POS_W-1:0] pos;
    logic             at_lsd;
    bcd_t             cur_code;
    bcd_t             dig_arr [NUM_DIGITS];

    scan_rst_sync #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (scan_rst),
        .sync_out (scan_hold)
    );

    assign step = scan_tick && !scan_hold;

    scan_sequencer #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (scan_hold),
        .advance (step),
        .pos     (pos),
        .at_lsd  (at_lsd),
        .strobe  (strobe)
    );

    // Slice the flat digit bus into one entry per digit.
    for (genvar gd = 0; gd < NUM_DIGITS; gd++) begin : g_unpack
        assign dig_arr[gd] = digits[gd*BCD_W +: BCD_W];
    end

    // Select the digit at the current scan position.
    always_comb begin
        cur_code = dig_arr[pos];
    end

    lead_blank_ctrl u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (scan_hold),
        .advance  (step),
        .at_lsd   (at_lsd),
        .cur_zero (cur_code == '0),
        .dp_req   (dp_req),
        .ovf      (ovf_latched),
        .blank    (blank_out)
    );

    seg_encoder u_seg (
        .code      (cur_code),
        .blank     (blank_out),
        .lamp_test (lamp_test),
        .seg       (seg_out)
    );

    assign bcd_out = cur_code;

endmodule

// File: rtl/mux_disp_scan_chk.sv
// Module: mux_disp_scan_chk
// Property checker for mux_disp_scan, bound into every instance.
module mux_disp_scan_chk #(
    parameter int NUM_DIGITS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_tick,
    input logic                  scan_hold,
    input logic                  ovf_latched,
    input logic                  lamp_test,
    input logic [6:0]            seg_out,
    input logic [NUM_DIGITS-1:0] strobe,
    input logic                  blank_out
);

    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobe) == 1);

    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !scan_hold && !strobe[0]) |=> (strobe == ($past(strobe) >> 1)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !scan_hold && strobe[0]) |=> strobe[NUM_DIGITS-1]);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_tick && !scan_hold) |=> $stable(strobe));

    p_hold_msd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_hold |=> strobe[NUM_DIGITS-1]);

    p_hold_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_hold |-> blank_out);

    p_lsd_shown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe[0] && !scan_hold) |-> !blank_out);

    p_ovf_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_latched && !scan_hold) |-> !blank_out);

    p_blank_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_out && !lamp_test) |-> (seg_out == 7'h00));

    p_lamp_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_test |-> (seg_out == 7'h7F));

endmodule

bind mux_disp_scan mux_disp_scan_chk #(
    .NUM_DIGITS (NUM_DIGITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_tick   (scan_tick),
    .scan_hold   (scan_hold),
    .ovf_latched (ovf_latched),
    .lamp_test   (lamp_test),
    .seg_out     (seg_out),
    .strobe      (strobe),
    .blank_out   (blank_out)
);

// File: tb/mux_disp_scan_test.sv
module mux_disp_scan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic        scan_rst = 1'b0;
    logic        dp_req = 1'b0;
    logic        ovf_latched = 1'b0;
    logic        lamp_test = 1'b0;
    logic [31:0] digits = '0;
    logic [3:0]  bcd_out;
    logic [6:0]  seg_out;
    logic [7:0]  strobe;
    logic        blank_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mux_disp_scan uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_tick   (scan_tick),
        .scan_rst    (scan_rst),
        .dp_req      (dp_req),
        .ovf_latched (ovf_latched),
        .lamp_test   (lamp_test),
        .digits      (digits),
        .bcd_out     (bcd_out),
        .seg_out     (seg_out),
        .strobe      (strobe),
        .blank_out   (blank_out)
    );

    function automatic logic [6:0] exp_seg(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;
            4'd2: return 7'h5B;  4'd3: return 7'h4F;
            4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;
            4'd8: return 7'h7F;  4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    // Pattern with k leading zeros, a nonzero first shown digit, mixed tail.
    function automatic logic [31:0] mk_pat(input int k);
        logic [31:0] d = '0;
        for (int i = 0; i < 8; i++) begin
            if (i == 7 - k)     d[i*4 +: 4] = 4'((k % 9) + 1);
            else if (i < 7 - k) d[i*4 +: 4] = 4'((i * 7 + k) % 10);
        end
        return d;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        scan_tick = 1'b1;
        @(posedge clk);
        #1 scan_tick = 1'b0;
    endtask

    // mode 0 plain, 1 decimal point at digit 5, 2 overflow, 3 lamp test.
    task automatic run_case(input logic [31:0] pat, input int mode);
        bit lead;
        int dpp;
        logic [3:0] d;
        logic eb;
        digits = pat; dp_req = 0; ovf_latched = (mode == 2); lamp_test = 0;
        scan_rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        tick();                       // must be ignored while held (R8)
        @(negedge clk);
        chk("R8 strobe held at MSD", 32'(strobe), 32'h80);
        chk("R8 forced blank", 32'(blank_out), 32'h1);
        chk("R8 segments dark", 32'(seg_out), 32'h0);
        scan_rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        lamp_test = (mode == 3);
        dpp = (mode == 1) ? 5 : -1;
        lead = 1'b1;
        for (int s = 0; s < 16; s++) begin
            int p = 7 - (s % 8);
            if (p == 7) lead = 1'b1;  // re-armed each scan (R9)
            dp_req = (p == dpp);
            #1;
            d = pat[p*4 +: 4];
            eb = lead && (d == 0) && (p != dpp) && (p != 0) && (mode != 2);
            chk("R2 strobe position", 32'(strobe), 32'(8'(1) << p));
            chk("R11 single strobe", $countones(strobe), 1);
            chk("R2 bcd bus", 32'(bcd_out), 32'(d));
            if (mode == 2)      chk("R7 overflow shows all", 32'(blank_out), 32'(eb));
            else if (p == 0)    chk("R6 last digit shown", 32'(blank_out), 32'(eb));
            else if (mode == 1) chk("R5 decimal point", 32'(blank_out), 32'(eb));
            else                chk("R4 leading zeros", 32'(blank_out), 32'(eb));
            if (mode == 3)      chk("R10 lamp test", 32'(seg_out), 32'h7F);
            else if (eb)        chk("R9 blank darkens", 32'(seg_out), 32'h0);
            else                chk("R3 segment code", 32'(seg_out), 32'(exp_seg(d)));
            lead = lead && (d == 0) && (p != dpp);
            tick();
        end
        dp_req = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset strobe", 32'(strobe), 32'h80);
        chk("R1 reset bcd", 32'(bcd_out), 32'h0);
        chk("R1 reset blank", 32'(blank_out), 32'h1);
        chk("R1 reset segments", 32'(seg_out), 32'h0);
        // R2: no tick leaves the position alone.
        repeat (4) @(posedge clk);
        #1 chk("R2 idle holds", 32'(strobe), 32'h80);
        for (int k = 0; k <= 8; k++)
            for (int m = 0; m < 4; m++)
                run_case(mk_pat(k), m);
        run_case(32'hFEDCBA98, 0);   // R3 invalid codes dark
        run_case(32'h0000A000, 0);   // R3/R4 invalid code ends leading zeros
        run_case(32'h00000000, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule